// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block takes one byte, offered together with a single-cycle valid strobe, and sends it out on one output wire as an asynchronous serial frame. The wire idles high. A frame is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop period. Three configuration inputs set the shape of each frame when its strobe is accepted. They choose a data width of five to eight bits, a parity mode of none, odd or even, and a stop period of one, one and a half or two bit times.

The bit time is a whole number of clock cycles. It is found by dividing the clock frequency parameter by the baud-rate parameter, and the baud rate defaults to 115200. A busy output is high for the whole of each frame. The surrounding logic waits for busy to be low before it offers the next byte. A strobe that arrives while busy is high is dropped.

The controller is a five-state machine. IDLE goes to START when a strobe is accepted. START goes to DATA after one bit time. DATA loops on itself once per data bit. After the last data bit, DATA goes to PARITY when parity is enabled and to STOP when it is not. PARITY goes to STOP after one bit time. STOP goes back to IDLE when the selected stop period has elapsed.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever busy is low, `line_out` is high and `busy` is low.
- R2: A strobe is accepted at a clock edge where `tx_valid` is high and the block is idle. From the next cycle, `line_out` is low for exactly one bit time as the start bit.
- R3: The data bits follow the start bit, least significant bit first, one bit time each. Their count is 5 + `cfg_len`, so `cfg_len` values 0, 1, 2 and 3 give 5, 6, 7 and 8 bits.
- R4: `cfg_par` selects the parity: 0 is none, 1 is odd, 2 is even and 3 is none. When parity is enabled, one parity bit of one bit time follows the data. It is computed only over the data bits in use. Even makes the number of ones in data plus parity even, and odd makes it odd.
- R5: The stop period holds `line_out` high. `cfg_stop` value 0 gives one bit time, 1 gives one bit time plus half a bit time (integer half), and 2 or 3 give two bit times.
- R6: One bit time is CLK_HZ / BAUD clock cycles, using integer division.
- R7: `busy` rises in the cycle after a strobe is accepted and stays high until the stop period ends. It is low in the cycle that follows the stop period.
- R8: The data and all three configuration inputs are captured at acceptance. Changing them during a frame does not alter that frame.
- R9: A strobe that arrives while busy is high is ignored. This includes a strobe in the last cycle of the stop period.
- R10: Reset in the middle of a frame forces `line_out` high and `busy` low at once, and the block then accepts a new frame normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_data | input | 8 | Byte to send; only the low 5 + `cfg_len` bits are sent |
| tx_valid | input | 1 | Send strobe |
| cfg_len | input | 2 | Data width select (5 + value) |
| cfg_par | input | 2 | Parity select: 0 none, 1 odd, 2 even, 3 none |
| cfg_stop | input | 2 | Stop period select: 0 one, 1 one and a half, 2 or 3 two bit times |
| line_out | output | 1 | Serial output line, high at idle |
| busy | output | 1 | High while a frame is in progress |

## Verification
The end of the stop period and a new strobe can fall in the same cycle. A strobe held in the last STOP cycle has to be dropped, while a strobe one cycle later, in IDLE, has to start a frame at once. The bench provokes this on many frames: it raises the strobe with junk data in the final stop cycle, then offers the real next byte in the very next cycle. It checks the output line cycle by cycle against a frame the bench builds itself, so an accepted junk byte or a lost real byte both show up as wrong line values. A second strobe in the middle of the frame, together with changes to the data and configuration inputs, exercises capture at acceptance in the same way.

// File: rtl/aft_pkg.sv
package aft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } aft_state_e;

    localparam int DATA_W  = 8;
    localparam int MIN_LEN = 5;

    localparam logic [1:0] PAR_ODD  = 2'd1;
    localparam logic [1:0] PAR_EVEN = 2'd2;

    localparam logic [1:0] STOP_ONE  = 2'd0;
    localparam logic [1:0] STOP_HALF = 2'd1;

endpackage

// File: rtl/aft_bit_timer.sv
module aft_bit_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = !clear && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/aft_parity_gen.sv
module aft_parity_gen #(
    parameter int DATA_W  = 8,
    parameter int MIN_LEN = 5
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              odd_mode,
    output logic              par_bit
);

    logic [DATA_W-1:0] used;

    for (genvar g = 0; g < DATA_W; g++) begin : g_mask
        assign used[g] = data[g] & (g < MIN_LEN + int'(len_sel));
    end

    assign par_bit = (^used) ^ odd_mode;

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
    import aft_pkg::*;
#(
    parameter int CLK_HZ = 50_000_000,
    parameter int BAUD   = 115200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic [1:0] cfg_stop,
    output logic       line_out,
    output logic       busy
);

    localparam int CYC   = CLK_HZ / BAUD;
    localparam int HALF  = CYC / 2;
    localparam int CNT_W = $clog2(2 * CYC + 1);

    localparam logic [CNT_W-1:0] LIM_ONE  = CNT_W'(CYC);
    localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(CYC + HALF);
    localparam logic [CNT_W-1:0] LIM_TWO  = CNT_W'(2 * CYC);

    aft_state_e        state_q, state_nx;
    logic              accept;
    logic              tick;
    logic [CNT_W-1:0]  limit;

    logic [DATA_W-1:0] shreg_q, shreg_nx;
    logic [2:0]        bitidx_q;
    logic [2:0]        last_idx;
    logic [1:0]        len_q;
    logic [1:0]        stop_q;
    logic              paren_q;
    logic              parbit_q;
    logic              par_new;

    assign accept   = (state_q == ST_IDLE) && tx_valid;
    assign last_idx = 3'(MIN_LEN - 1) + {1'b0, len_q};

    // parity over the used data bits, evaluated at acceptance
    aft_parity_gen #(
        .DATA_W (DATA_W),
        .MIN_LEN(MIN_LEN)
    ) u_par (
        .data    (tx_data),
        .len_sel (cfg_len),
        .odd_mode(cfg_par == PAR_ODD),
        .par_bit (par_new)
    );

    // per-state period length
    always_comb begin
        limit = LIM_ONE;
        if (state_q == ST_STOP) begin
            unique case (stop_q)
                STOP_ONE:  limit = LIM_ONE;
                STOP_HALF: limit = LIM_HALF;
                default:   limit = LIM_TWO;
            endcase
        end
    end

    aft_bit_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(state_q == ST_IDLE),
        .limit(limit),
        .done (tick)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_nx = ST_START;
            ST_START:  if (tick) state_nx = ST_DATA;
            ST_DATA: begin
                if (tick && bitidx_q == last_idx) begin
                    state_nx = paren_q ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: if (tick) state_nx = ST_STOP;
            ST_STOP:   if (tick) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // data shifter
    always_comb begin
        shreg_nx = shreg_q;
        if (accept) begin
            shreg_nx = tx_data;
        end else if (state_q == ST_DATA && tick) begin
            shreg_nx = shreg_q >> 1;
        end
    end

    // captured frame settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitidx_q <= '0;
            len_q    <= '0;
            stop_q   <= '0;
            paren_q  <= 1'b0;
            parbit_q <= 1'b0;
        end else begin
            shreg_q <= shreg_nx;
            if (accept) begin
                bitidx_q <= '0;
                len_q    <= cfg_len;
                stop_q   <= cfg_stop;
                paren_q  <= (cfg_par == PAR_ODD) || (cfg_par == PAR_EVEN);
                parbit_q <= par_new;
            end else if (state_q == ST_DATA && tick) begin
                bitidx_q <= bitidx_q + 3'd1;
            end
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_out <= 1'b1;
            busy     <= 1'b0;
        end else begin
            busy <= (state_nx != ST_IDLE);
            unique case (state_nx)
                ST_START:  line_out <= 1'b0;
                ST_DATA:   line_out <= shreg_nx[0];
                ST_PARITY: line_out <= parbit_q;
                default:   line_out <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic line_out,
    input logic busy
);

    // R1: idle line is high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> line_out);

    // R2: the first busy cycle carries the start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_out);

    // R7: busy only starts after a strobe
    assert_busy_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_valid));

    // R5: the last busy cycle is part of the high stop period
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(line_out));

endmodule

bind async_frame_tx async_frame_tx_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_valid(tx_valid),
    .line_out(line_out),
    .busy    (busy)
);

// File: tb/async_frame_tx_bench.sv
module async_frame_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 10_000_000;
    localparam int BAUD       = 1_000_000;
    localparam int B          = CLK_HZ / BAUD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic [1:0] cfg_len = '0;
    logic [1:0] cfg_par = '0;
    logic [1:0] cfg_stop = '0;
    logic       line_out;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    async_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_async_frame_tx (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .line_out(line_out), .busy(busy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int stop_cycles(input logic [1:0] s);
        if (s == 2'd0) return B;
        if (s == 2'd1) return B + B / 2;
        return 2 * B;
    endfunction

    // sends one frame starting at a negedge, ends at the negedge after busy falls
    task automatic run_frame(input logic [7:0] d, input logic [1:0] len,
                             input logic [1:0] par, input logic [1:0] stp, input bit disturb);
        logic [11:0] eb;
        int n, nb, ones, total, k;
        bit pen;
        string tag;
        n = 5 + int'(len);
        pen = (par == 2'd1) || (par == 2'd2);
        eb = '1;
        eb[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            eb[1 + i] = d[i];
            ones += int'(d[i]);
        end
        if (pen) eb[1 + n] = (par == 2'd2) ? ones[0] : ~ones[0];
        nb = 1 + n + int'(pen);
        total = nb * B + stop_cycles(stp);
        tx_data = d; cfg_len = len; cfg_par = par; cfg_stop = stp; tx_valid = 1'b1;
        @(posedge clk);
        for (int j = 0; j <= total; j++) begin
            @(negedge clk);
            if (j == 0) begin
                tx_valid = 1'b0;
                if (disturb) begin // R8: inputs change mid-frame
                    tx_data = ~d; cfg_len = 2'($urandom); cfg_par = 2'($urandom);
                    cfg_stop = 2'($urandom);
                end
            end
            if (disturb && j == 3 * B + 2) begin tx_valid = 1'b1; tx_data = 8'($urandom); end // R9
            if (disturb && j == 3 * B + 3) tx_valid = 1'b0;
            if (disturb && j == total - 1) begin tx_valid = 1'b1; tx_data = 8'($urandom); end // R9 last stop cycle
            if (j < total) begin
                k = j / B;
                if (k == 0) tag = "R2";
                else if (k <= n) tag = "R3";
                else if (k < nb) tag = "R4";
                else tag = "R5";
                if (disturb) tag = {tag, " R8 R9"};
                check(line_out == (k < nb ? eb[k] : 1'b1), tag, int'(line_out),
                      int'(k < nb ? eb[k] : 1'b1));
                check(busy == 1'b1, "R7", int'(busy), 1);
            end else begin
                tx_valid = 1'b0;
                check(busy == 1'b0, "R6 R7", int'(busy), 0);
                check(line_out == 1'b1, "R1", int'(line_out), 1);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(line_out == 1'b1, "R1", int'(line_out), 1);
        check(busy == 1'b0, "R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out == 1'b1 && busy == 1'b0, "R1", int'(line_out), 1);

        // directed: every length, parity and stop combination
        for (int l = 0; l < 4; l++)
            for (int p = 0; p < 4; p++)
                for (int s = 0; s < 4; s++)
                    run_frame(8'hA5 ^ 8'(l * 16 + p * 4 + s), 2'(l), 2'(p), 2'(s), 1'b0);
        run_frame(8'h00, 2'd3, 2'd1, 2'd1, 1'b0);  // R4 odd, no ones
        run_frame(8'hFF, 2'd3, 2'd2, 2'd0, 1'b0);  // R4 even, all ones
        run_frame(8'hE0, 2'd0, 2'd1, 2'd0, 1'b0);  // R4 unused high bits ignored

        // random back-to-back frames with disturbance
        for (int r = 0; r < 40; r++) begin
            run_frame(8'($urandom), 2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
            if (r % 8 == 7) repeat (3) @(negedge clk);
        end

        // R10: reset mid-frame
        tx_data = 8'h3C; cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd0; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (2 * B + 3) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(line_out == 1'b1, "R10", int'(line_out), 1);
        check(busy == 1'b0, "R10", int'(busy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(line_out == 1'b1 && busy == 1'b0, "R10", int'(busy), 0);
        run_frame(8'h96, 2'd2, 2'd2, 2'd2, 1'b0); // R10 recovery

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule